// File: doc/BRIEF.md
# Kick-updated fractional clock divider

This block derives two slower CPU-class clocks from one fast source clock. For each output, a 5-bit setting v selects how many source pulses survive in every window of 32: exactly 32 − v of them are kept. The kept pulses then drive a toggle stage that divides by a fixed two. The resulting output rate is source × (32 − v) / 64. A value of 0 gives half the source rate, and 31 gives 1/64 of it.

Software programs the block through a small 32-bit register port. The two settings are written into a pending control register. They stay pending until software writes a 1 to the apply flag in a separate update register. At the next 32-cycle window edge, the block copies the pending settings into its working copy and clears the flag in that same cycle. Software polls the flag, and while it reads 1 the block is busy: control writes made in that time are dropped. Because the working copy changes only on a window edge, a ratio never changes partway through a window.

The kept pulses are spread across the window by an accumulator. Each cycle it adds the multiplier 32 − v, and a pulse is kept whenever the sum passes 32. The keep decision is re-registered on the falling edge of the source clock and ANDed with the clock. The gated clock is therefore free of runt pulses.

Top module: `clkfrac_top`

## Requirements
- R1: After reset, both pending fields and the apply flag read 0, and both outputs run at the full ratio: the divided output toggles on every source cycle.
- R2: The control register sits at byte address 0x808. Output 0's field is bits 4:0 and output 1's field is bits 12:8. A read returns the pending fields, and all other bits read 0.
- R3: The update register sits at byte address 0x804, and the apply flag is bit 31. Writing a word with bit 31 set raises the flag. Writing a word with bit 31 clear has no effect. A read returns the flag in bit 31, and all other bits read 0.
- R4: The block clears the apply flag within 32 source cycles of it being raised. The clear always lands on the same phase of the free-running 32-cycle window, and the working fields are loaded in that same cycle.
- R5: A control-register write made while the apply flag is set is ignored. The pending fields and the later output rate keep the earlier values.
- R6: Pending fields that have not been applied do not change either output's rate.
- R7: In every 32 consecutive source cycles, output n's gated clock carries exactly 32 − v rising edges, where v is output n's working field.
- R8: Output n's divided clock toggles exactly once per kept pulse, giving 2·(32 − v) toggles in 64 cycles.
- R9: Reads of addresses other than 0x804 and 0x808 return 0. Writes to those addresses change no register.
- R10: Kept pulses are spread evenly. Within a steady ratio, the spacings between consecutive gated-clock edges differ from each other by at most one source cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| gated_clk | output | 2 | Source clock with dropped pulses, one bit per output |
| div_clk | output | 2 | Gated pulses divided by two, one bit per output |

## Verification
The bench runs several field pairs with both ends of the range: 0, which keeps every pulse, and 31, which keeps one pulse per window. It also uses unequal fields on the two outputs. A swapped or misplaced field position shows up as an output running at the other output's rate. An off-by-one in the 32 − v mapping shows up as a pulse count that is wrong by two per 64 cycles. The bench records the window phase at which each apply completes. An apply that finishes early, before the window edge, shows up as a phase that differs between vectors. It also writes the control register while the flag is still up. A design that accepted that write would report the new fields on readback and run at the wrong rate. Pulse spacing is measured edge to edge, so a scheme that bunches the kept pulses together fails the spacing check even when the total count is right.

// File: rtl/clkfrac_pkg.sv
package clkfrac_pkg;
    localparam int FIELD_W     = 5;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int KICK_BIT    = 31;
    localparam int LANE_STRIDE = 8;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h808;
    localparam logic [ADDR_W-1:0] UPD_OFS  = 12'h804;
endpackage

// File: rtl/clkfrac_regs.sv
module clkfrac_regs
    import clkfrac_pkg::*;
#(
    parameter int N_OUT   = 2,
    parameter int FW      = FIELD_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int KBIT    = KICK_BIT,
    parameter int STRIDE  = LANE_STRIDE,
    parameter logic [AW-1:0] CTRL_A = CTRL_OFS,
    parameter logic [AW-1:0] UPD_A  = UPD_OFS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DW-1:0]               wdata_i,
    output logic [DW-1:0]               rdata_o,
    output logic [N_OUT-1:0][FW-1:0]    work_o,
    output logic                        win_end_o
);
    typedef struct packed {
        logic [N_OUT-1:0][FW-1:0] pend;
        logic [N_OUT-1:0][FW-1:0] work;
        logic                     kick;
        logic [FW-1:0]            pos;
    } regs_t;

    regs_t s_d, s_q;
    logic  ctrl_wr, upd_wr, boundary;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        s_d      = s_q;
        s_d.pos  = s_q.pos + 1'b1;
        boundary = (s_q.pos == '1);
        ctrl_wr  = wr_i && (addr_i == CTRL_A);
        upd_wr   = wr_i && (addr_i == UPD_A);
        if (ctrl_wr && !s_q.kick) begin
            for (int i = 0; i < N_OUT; i++) begin
                s_d.pend[i] = wdata_i[i*STRIDE +: FW];
            end
        end
        if (upd_wr && wdata_i[KBIT]) begin
            s_d.kick = 1'b1;
        end
        if (boundary && s_q.kick) begin
            s_d.work = s_q.pend;
            s_d.kick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_A) begin
            for (int i = 0; i < N_OUT; i++) begin
                rdata_o[i*STRIDE +: FW] = s_q.pend[i];
            end
        end else if (addr_i == UPD_A) begin
            rdata_o[KBIT] = s_q.kick;
        end
    end

    assign work_o    = s_q.work;
    assign win_end_o = boundary;

    // R4: flag drops only on the last cycle of a window
    a_r4_clear_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.kick) |-> ($past(s_q.pos) == '1));

    // R4: working fields change only as a new window opens
    a_r4_work_window_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pos != '0) |-> $stable(s_q.work));

    // R5: busy-time control writes are dropped
    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && s_q.kick) |=> (s_q.pend == $past(s_q.pend)));
endmodule

// File: rtl/clkfrac_lane.sv
module clkfrac_lane
    import clkfrac_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] field_i,
    input  logic          win_end_i,
    output logic          gated_o,
    output logic          div_o
);
    localparam logic [FW:0] WIN_V = (FW+1)'(1) << FW;

    typedef struct packed {
        logic [FW-1:0] acc;
        logic          keep;
        logic          div;
    } lane_t;

    lane_t       s_d, s_q;
    logic [FW:0] mult, sum;
    logic        en_n_q;

    always_comb begin
        s_d      = s_q;
        mult     = WIN_V - {1'b0, field_i};
        sum      = {1'b0, s_q.acc} + mult;
        s_d.keep = sum[FW];
        s_d.acc  = win_end_i ? '0 : sum[FW-1:0];
        s_d.div  = s_q.keep ? ~s_q.div : s_q.div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_n_q <= 1'b0;
        end else begin
            en_n_q <= s_q.keep;
        end
    end

    assign gated_o = clk & en_n_q;
    assign div_o   = s_q.div;

    // R7: a zero field keeps every pulse
    a_r7_full_rate_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (field_i == '0) |=> s_q.keep);

    // R8: the divider moves only on a kept pulse
    a_r8_div_follows_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.div) |-> $past(s_q.keep));
endmodule

// File: rtl/clkfrac_top.sv
module clkfrac_top
    import clkfrac_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int FW    = FIELD_W,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [N_OUT-1:0] gated_clk,
    output logic [N_OUT-1:0] div_clk
);
    logic [N_OUT-1:0][FW-1:0] work;
    logic                     win_end;

    clkfrac_regs #(
        .N_OUT (N_OUT),
        .FW    (FW),
        .AW    (AW),
        .DW    (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .work_o    (work),
        .win_end_o (win_end)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        clkfrac_lane #(.FW(FW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .field_i   (work[g]),
            .win_end_i (win_end),
            .gated_o   (gated_clk[g]),
            .div_o     (div_clk[g])
        );
    end
endmodule

// File: tb/clkfrac_top_tb.sv
module clkfrac_top_tb;
    localparam int NV = 7;
    localparam int VF0 [NV] = '{0, 31, 1, 16, 5, 31, 12};
    localparam int VF1 [NV] = '{0, 0, 30, 8, 27, 31, 20};
    localparam logic [11:0] A_CTRL = 12'h808;
    localparam logic [11:0] A_UPD  = 12'h804;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  gated_clk, div_clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int phase_ref = -1;
    bit done = 0, meas = 0;
    int  gcnt [2];
    int  gmin [2];
    int  gmax [2];
    time glast [2];
    bit  ghave [2];

    clkfrac_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gated_clk(gated_clk), .div_clk(div_clk)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic note_edge(input int i);
        int gap;
        if (meas) begin
            gcnt[i]++;
            if (ghave[i]) begin
                gap = int'(($time - glast[i]) / 4);
                if (gap < gmin[i]) gmin[i] = gap;
                if (gap > gmax[i]) gmax[i] = gap;
            end
            glast[i] = $time;
            ghave[i] = 1;
        end
    endtask

    always @(posedge gated_clk[0]) note_edge(0);
    always @(posedge gated_clk[1]) note_edge(1);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Measure 64 cycles; return toggle counts of div_clk
    task automatic measure(output int t0, output int t1);
        logic [1:0] prev;
        @(negedge clk);
        t0 = 0; t1 = 0;
        for (int i = 0; i < 2; i++) begin
            gcnt[i] = 0; gmin[i] = 1000; gmax[i] = 0; ghave[i] = 0;
        end
        prev = div_clk;
        meas = 1;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (div_clk[0] != prev[0]) t0++;
            if (div_clk[1] != prev[1]) t1++;
            prev = div_clk;
        end
        meas = 0;
    endtask

    task automatic check_rates(input int f0, input int f1, input string tag);
        int t0, t1;
        measure(t0, t1);
        chk(t0 == 2*(32-f0), {tag, " R8 div0 toggles"}, t0, 2*(32-f0));
        chk(t1 == 2*(32-f1), {tag, " R8 div1 toggles"}, t1, 2*(32-f1));
        chk(gcnt[0] == 2*(32-f0), {tag, " R7 gated0 edges"}, gcnt[0], 2*(32-f0));
        chk(gcnt[1] == 2*(32-f1), {tag, " R7 gated1 edges"}, gcnt[1], 2*(32-f1));
        chk(gmax[0] - gmin[0] <= 1, {tag, " R10 spread0"}, gmax[0] - gmin[0], 1);
        chk(gmax[1] - gmin[1] <= 1, {tag, " R10 spread1"}, gmax[1] - gmin[1], 1);
    endtask

    // Raise the flag and wait for the block to drop it (R4)
    task automatic kick_and_wait(input string tag);
        logic [31:0] d;
        int n, ph;
        wr(A_UPD, 32'h8000_0000);
        n = 0;
        rd(A_UPD, d);
        chk(d == 32'h8000_0000, {tag, " R3 flag set"}, int'(d[31]), 1);
        while (d[31] && n < 40) begin
            n++;
            rd(A_UPD, d);
        end
        chk(n <= 32 && !d[31], {tag, " R4 clear latency"}, n, 32);
        ph = cyc % 32;
        if (phase_ref < 0) phase_ref = ph;
        chk(ph == phase_ref, {tag, " R4 clear phase"}, ph, phase_ref);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog (all requirements) actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d);
        chk(d == 0, "R1 ctrl after reset", int'(d), 0);
        rd(A_UPD, d);
        chk(d == 0, "R1 flag after reset", int'(d), 0);
        check_rates(0, 0, "R1 reset");

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            w = 32'hFFFF_E0E0 | (32'(VF1[v]) << 8) | 32'(VF0[v]);
            wr(A_CTRL, w);
            rd(A_CTRL, d);
            chk(d == ((32'(VF1[v]) << 8) | 32'(VF0[v])), "R2 readback",
                int'(d), (VF1[v] << 8) | VF0[v]);
            kick_and_wait("vec");
            check_rates(VF0[v], VF1[v], "vec");
        end

        // R6: pending without flag leaves rate alone
        wr(A_CTRL, (32'd3 << 8) | 32'd3);
        rd(A_CTRL, d);
        chk(d == 32'h0303, "R6 pending readback", int'(d), 32'h0303);
        repeat (40) @(negedge clk);
        check_rates(12, 20, "R6 unapplied");

        // R5: control write while busy is dropped
        wr(A_UPD, 32'h8000_0000);
        wr(A_CTRL, (32'd9 << 8) | 32'd9);
        begin
            int n;
            n = 0;
            rd(A_UPD, d);
            while (d[31] && n < 40) begin
                n++;
                rd(A_UPD, d);
            end
            chk(!d[31], "R5 flag cleared", int'(d[31]), 0);
        end
        rd(A_CTRL, d);
        chk(d == 32'h0303, "R5 busy write dropped", int'(d), 32'h0303);
        repeat (8) @(negedge clk);
        check_rates(3, 3, "R5 rate");

        // R3: writes with bit 31 clear do nothing
        wr(A_UPD, 32'h7FFF_FFFF);
        rd(A_UPD, d);
        chk(d == 0, "R3 zero write no flag", int'(d), 0);
        wr(A_CTRL, 32'h0000_0A0A);
        wr(A_UPD, 32'h0000_0000);
        rd(A_UPD, d);
        chk(d == 0, "R3 clear write no flag", int'(d), 0);
        repeat (40) @(negedge clk);
        check_rates(3, 3, "R3 no apply");

        // R9: other addresses
        wr(12'h800, 32'hFFFF_FFFF);
        wr(12'h80C, 32'hFFFF_FFFF);
        rd(12'h800, d);
        chk(d == 0, "R9 read 0x800", int'(d), 0);
        rd(12'h80C, d);
        chk(d == 0, "R9 read 0x80C", int'(d), 0);
        rd(A_CTRL, d);
        chk(d == 32'h0A0A, "R9 ctrl untouched", int'(d), 32'h0A0A);
        rd(A_UPD, d);
        chk(d == 0, "R9 flag untouched", int'(d), 0);

        // Apply the last pending pair to close the loop
        kick_and_wait("final");
        check_rates(10, 10, "final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule